// File: doc/BRIEF.md
# Sector Record Update Sequencer

This block rewrites chosen records of a single disk sector and leaves the rest of that sector as it was. A command carries the target cylinder, head and sector, plus an update mode. The mode either replaces the data record alone or replaces both the label and the data records. The sequencer checks that the heads sit on the requested cylinder. It then claims the shared field engines and waits for the requested sector to pass under the head. After that it steps through the sector's three records in fixed order: header (code 0), label (code 1) and data (code 2).

Each record is either read, when it must stay intact, or written, when it is being replaced. A single sector pass therefore switches from reading to writing partway through. The block does not serialize any bits itself. It hands each record to a shared read-field engine or a shared write-field engine through a one-cycle request pulse and a one-cycle done pulse. The same engines also serve separate read-sector and write-sector machines. A small arbiter gives them to one machine at a time and shows the current holder as a one-hot owner vector.

The controller has these states, all named here:

- IDLE: accepts a command.
- ARB: waits for the engine grant.
- SEEKSEC: waits for the target sector mark.
- ISSUE: pulses one engine request.
- WAIT: waits for that engine's done pulse.
- CLOSE: drops write gate after the final write.
- FINISH: a one-cycle done pulse with the status, which releases ownership.

The transitions are:

- IDLE→FINISH on a cylinder mismatch.
- IDLE→ARB on a cylinder match.
- ARB→SEEKSEC on grant.
- SEEKSEC→ISSUE on the matching mark.
- ISSUE→WAIT always.
- WAIT→ISSUE when a record finishes and more records remain.
- WAIT→FINISH on a read error.
- WAIT→CLOSE after the data record is written.
- CLOSE→FINISH always.
- FINISH→IDLE always.

Top module: `sector_update_seq`

## Requirements
- R1: After reset, busy, done, write gate, both engine requests and the owner vector are all low, and status is 0.
- R2: A command whose cylinder differs from cur_cyl completes with status 2 and a done pulse in the cycle after acceptance. It issues no engine request and never takes engine ownership.
- R3: No engine request is issued until sector_mark is seen together with cur_sector equal to the target sector. Marks that arrive with any other sector number are ignored.
- R4: Records are handled in the order header (fld_rec=0), label (1), data (2), one request per record. fld_head carries the command's head with every request.
- R5: In mode 0 (data only), header and label are read and the data record is written.
- R6: In mode 1 (label plus data), the header is read and then the label and data records are written.
- R7: Write gate rises with the first write request and stays high through the last write's done pulse. It is low in the cycle after that done pulse, and it is low whenever a read is pending.
- R8: A read done pulse with rd_err high ends the command with status 1. No further request is issued, and write gate is never raised during that command.
- R9: The owner vector is one-hot or zero. Requester index 0 is this sequencer, and indices 1 and up are oth_req bits. When the engines are free, the lowest requesting index wins. An owner keeps the grant while its request stays high. The sequencer issues no engine request without holding the grant.
- R10: A successful command ends with done high for one cycle and status 0. In the next cycle busy is low and the owner vector has released the sequencer.
- R11: cmd_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_cyl | input | CYL_W | Target cylinder |
| cmd_head | input | HEAD_W | Target head |
| cmd_sector | input | SEC_W | Target sector |
| cmd_mode | input | 1 | 0 = data only, 1 = label plus data |
| cur_cyl | input | CYL_W | Cylinder the heads sit on |
| cur_sector | input | SEC_W | Number of the sector now arriving |
| sector_mark | input | 1 | One-cycle pulse at each sector start |
| oth_req | input | N_MACH-1 | Engine requests from the other machines |
| eng_owner | output | N_MACH | One-hot engine owner, bit 0 = this sequencer |
| fld_rec | output | 2 | Record code for the engine request |
| fld_head | output | HEAD_W | Head for the engine request |
| rd_req | output | 1 | Read-field engine request pulse |
| rd_done | input | 1 | Read-field engine done pulse |
| rd_err | input | 1 | Read failure, valid with rd_done |
| wr_req | output | 1 | Write-field engine request pulse |
| wr_done | input | 1 | Write-field engine done pulse |
| wgate | output | 1 | Write gate |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 read error, 2 wrong cylinder |

## Verification
The update path is tried in both modes, on a low sector, a mid sector and the highest sector number, with both heads. Each expected record operation is queued and matched against the engine requests, which separates a correct read/write split per mode from a swapped or shifted one. Read failures are injected on the header and on the label to show that the abort happens before any write gate activity in either mode. Decoy sector marks, a cylinder mismatch, a command sent while busy, and competing machines holding or racing for the engines each isolate one guard of the sequence.

// File: rtl/sus_pkg.sv
package sus_pkg;

    // Record codes in on-disk order; the engines decode them
    typedef enum logic [1:0] {
        REC_HDR = 2'd0,
        REC_LBL = 2'd1,
        REC_DAT = 2'd2
    } rec_e;

    typedef enum logic [1:0] {
        STS_OK     = 2'd0,
        STS_RDERR  = 2'd1,
        STS_CYLERR = 2'd2
    } sts_e;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_LBLDAT = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARB,
        S_SEEKSEC,
        S_ISSUE,
        S_WAIT,
        S_CLOSE,
        S_FINISH
    } state_e;

endpackage

// File: rtl/sus_arbiter.sv
module sus_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] owner
);

    logic [N-1:0] pick;

    // lowest requesting index wins
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= '0;
        end else if (owner == '0) begin
            owner <= pick;
        end else if ((owner & req) == '0) begin
            owner <= '0;
        end
    end

    // R9
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner));

    // R9
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner != '0) && ((owner & req) != '0)) |=> (owner == $past(owner)));

endmodule

// File: rtl/sus_rec_plan.sv
module sus_rec_plan (
    input  logic       mode,
    input  logic [1:0] rec,
    output logic       is_wr,
    output logic       is_last
);
    import sus_pkg::*;

    always_comb begin
        unique case (rec)
            REC_HDR: is_wr = 1'b0;
            REC_LBL: is_wr = (mode == MODE_LBLDAT);
            REC_DAT: is_wr = 1'b1;
            default: is_wr = 1'b0;
        endcase
        is_last = (rec == REC_DAT);
    end

endmodule

// File: rtl/sus_fsm.sv
module sus_fsm #(
    parameter int CYL_W  = 8,
    parameter int HEAD_W = 1,
    parameter int SEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CYL_W-1:0]  cmd_cyl,
    input  logic [HEAD_W-1:0] cmd_head,
    input  logic [SEC_W-1:0]  cmd_sector,
    input  logic              cmd_mode,
    input  logic [CYL_W-1:0]  cur_cyl,
    input  logic [SEC_W-1:0]  cur_sector,
    input  logic              sector_mark,
    input  logic              grant,
    input  logic              rd_done,
    input  logic              rd_err,
    input  logic              wr_done,
    output logic              own_req,
    output logic [1:0]        fld_rec,
    output logic [HEAD_W-1:0] fld_head,
    output logic              rd_req,
    output logic              wr_req,
    output logic              wgate,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);
    import sus_pkg::*;

    state_e            state;
    logic [HEAD_W-1:0] tgt_head;
    logic [SEC_W-1:0]  tgt_sec;
    logic              mode_q;
    logic [1:0]        rec_q;
    logic [1:0]        sts_q;
    logic              is_wr;
    logic              is_last;
    logic              hit_mark;

    sus_rec_plan u_plan (
        .mode    (mode_q),
        .rec     (rec_q),
        .is_wr   (is_wr),
        .is_last (is_last)
    );

    assign hit_mark = sector_mark && (cur_sector == tgt_sec);

    // state register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tgt_head <= '0;
            tgt_sec  <= '0;
            mode_q   <= 1'b0;
            rec_q    <= REC_HDR;
            sts_q    <= STS_OK;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        tgt_head <= cmd_head;
                        tgt_sec  <= cmd_sector;
                        mode_q   <= cmd_mode;
                        rec_q    <= REC_HDR;
                        if (cmd_cyl != cur_cyl) begin
                            sts_q <= STS_CYLERR;
                            state <= S_FINISH;
                        end else begin
                            state <= S_ARB;
                        end
                    end
                end
                S_ARB: begin
                    if (grant) state <= S_SEEKSEC;
                end
                S_SEEKSEC: begin
                    if (hit_mark) begin
                        rec_q <= REC_HDR;
                        state <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (!is_wr && rd_done) begin
                        if (rd_err) begin
                            sts_q <= STS_RDERR;
                            state <= S_FINISH;
                        end else begin
                            rec_q <= rec_q + 2'd1;
                            state <= S_ISSUE;
                        end
                    end else if (is_wr && wr_done) begin
                        if (is_last) begin
                            state <= S_CLOSE;
                        end else begin
                            rec_q <= rec_q + 2'd1;
                            state <= S_ISSUE;
                        end
                    end
                end
                S_CLOSE: begin
                    sts_q <= STS_OK;
                    state <= S_FINISH;
                end
                S_FINISH: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy    = (state != S_IDLE);
        own_req = 1'b0;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        wgate   = 1'b0;
        done    = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_ARB:     own_req = 1'b1;
            S_SEEKSEC: own_req = 1'b1;
            S_ISSUE: begin
                own_req = 1'b1;
                rd_req  = !is_wr;
                wr_req  = is_wr;
                wgate   = is_wr;
            end
            S_WAIT: begin
                own_req = 1'b1;
                wgate   = is_wr;
            end
            S_CLOSE:   own_req = 1'b1;
            S_FINISH:  done = 1'b1;
            default:   ;
        endcase
        fld_rec  = rec_q;
        fld_head = tgt_head;
        status   = sts_q;
    end

    // R9
    req_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> grant);

    // R7
    wgate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wgate) |-> $past(wr_done));

    // R7
    wgate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wgate) |-> wr_req);

    // R8
    rderr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !is_wr && rd_done && rd_err) |=> (done && !wgate));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R3
    sector_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEEKSEC && !hit_mark) |=> !(rd_req || wr_req));

endmodule

// File: rtl/sector_update_seq.sv
module sector_update_seq #(
    parameter int CYL_W  = 8,
    parameter int HEAD_W = 1,
    parameter int SEC_W  = 4,
    parameter int N_MACH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CYL_W-1:0]  cmd_cyl,
    input  logic [HEAD_W-1:0] cmd_head,
    input  logic [SEC_W-1:0]  cmd_sector,
    input  logic              cmd_mode,
    input  logic [CYL_W-1:0]  cur_cyl,
    input  logic [SEC_W-1:0]  cur_sector,
    input  logic              sector_mark,
    input  logic [N_MACH-2:0] oth_req,
    output logic [N_MACH-1:0] eng_owner,
    output logic [1:0]        fld_rec,
    output logic [HEAD_W-1:0] fld_head,
    output logic              rd_req,
    input  logic              rd_done,
    input  logic              rd_err,
    output logic              wr_req,
    input  logic              wr_done,
    output logic              wgate,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);

    localparam int SELF = 0;

    logic own_req;
    logic grant;

    sus_arbiter #(.N(N_MACH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({oth_req, own_req}),
        .owner (eng_owner)
    );

    assign grant = eng_owner[SELF];

    sus_fsm #(
        .CYL_W  (CYL_W),
        .HEAD_W (HEAD_W),
        .SEC_W  (SEC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_cyl     (cmd_cyl),
        .cmd_head    (cmd_head),
        .cmd_sector  (cmd_sector),
        .cmd_mode    (cmd_mode),
        .cur_cyl     (cur_cyl),
        .cur_sector  (cur_sector),
        .sector_mark (sector_mark),
        .grant       (grant),
        .rd_done     (rd_done),
        .rd_err      (rd_err),
        .wr_done     (wr_done),
        .own_req     (own_req),
        .fld_rec     (fld_rec),
        .fld_head    (fld_head),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .wgate       (wgate),
        .busy        (busy),
        .done        (done),
        .status      (status)
    );

endmodule

// File: tb/test_sector_update_seq.sv
`timescale 1ns/1ps
module test_sector_update_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_cyl = '0;
    logic [0:0] cmd_head = '0;
    logic [3:0] cmd_sector = '0;
    logic       cmd_mode = 1'b0;
    logic [7:0] cur_cyl = 8'd40;
    logic [3:0] cur_sector = '0;
    logic       sector_mark = 1'b0;
    logic [1:0] oth_req = '0;
    logic [2:0] eng_owner;
    logic [1:0] fld_rec;
    logic [0:0] fld_head;
    logic       rd_req, wr_req, wgate, busy, done;
    logic       rd_done, rd_err, wr_done;
    logic [1:0] status;

    int checks = 0;
    int bad = 0;
    int ops_seen = 0;
    int wg_cnt = 0;
    int err_rec = -1;
    bit finished = 0;
    bit last_wr_pending = 0;
    string cur_tag = "R1";
    int exp_ops[$];
    int exp_stat[$];

    int r_code, r_exp, r_rec, d_exp;
    bit r_isw;

    always #4 clk = ~clk;

    sector_update_seq i_sector_update_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cyl(cmd_cyl),
        .cmd_head(cmd_head), .cmd_sector(cmd_sector), .cmd_mode(cmd_mode),
        .cur_cyl(cur_cyl), .cur_sector(cur_sector), .sector_mark(sector_mark),
        .oth_req(oth_req), .eng_owner(eng_owner), .fld_rec(fld_rec),
        .fld_head(fld_head), .rd_req(rd_req), .rd_done(rd_done), .rd_err(rd_err),
        .wr_req(wr_req), .wr_done(wr_done), .wgate(wgate), .busy(busy),
        .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // driver side: queue expected engine operations (wr*16 + head*4 + rec)
    task automatic push_plan(input int head, input bit mode, input int erec);
        for (int r = 0; r < 3; r++) begin
            bit w;
            w = (r == 2) || (mode && r == 1);
            if (erec >= 0 && r > erec) break;
            exp_ops.push_back((w ? 16 : 0) + head * 4 + r);
        end
        exp_stat.push_back(erec >= 0 ? 1 : 0);
    endtask

    task automatic send_cmd(input int cyl, input int head, input int sec, input bit mode);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_cyl    = 8'(cyl);
        cmd_head   = 1'(head);
        cmd_sector = 4'(sec);
        cmd_mode   = mode;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic mark(input int sec);
        cur_sector  = 4'(sec);
        sector_mark = 1'b1;
        @(negedge clk);
        sector_mark = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic do_update(input int head, input int sec, input bit mode, input int erec);
        int n;
        int wg0;
        err_rec = erec;
        push_plan(head, mode, erec);
        wg0 = wg_cnt;
        send_cmd(40, head, sec, mode);
        repeat (3) @(negedge clk);
        n = ops_seen;
        mark((sec + 1) % 16);
        repeat (2) @(negedge clk);
        chk(ops_seen == n, "R3", ops_seen, n);
        mark(sec);
        wait_idle();
        chk(busy == 1'b0, "R10", busy, 0);
        chk(eng_owner == 3'b000, "R10", eng_owner, 0);
        if (erec >= 0) chk(wg_cnt == wg0, "R8", wg_cnt - wg0, 0);
        err_rec = -1;
    endtask

    // wgate activity counter
    initial forever begin
        @(negedge clk);
        if (wgate) wg_cnt++;
    end

    // field engine model and operation monitor
    initial begin
        rd_done = 1'b0; wr_done = 1'b0; rd_err = 1'b0;
        forever begin
            @(negedge clk);
            rd_done = 1'b0; wr_done = 1'b0; rd_err = 1'b0;
            if (last_wr_pending) begin
                chk(wgate == 1'b0, "R7", wgate, 0);
                last_wr_pending = 0;
            end
            if (rd_req || wr_req) begin
                r_isw  = wr_req;
                r_rec  = int'(fld_rec);
                r_code = (wr_req ? 16 : 0) + int'(fld_head) * 4 + r_rec;
                ops_seen++;
                if (exp_ops.size() == 0) begin
                    chk(1'b0, "R4", r_code, -1);
                end else begin
                    r_exp = exp_ops.pop_front();
                    chk(r_code == r_exp, cur_tag, r_code, r_exp);
                end
                repeat (2) @(negedge clk);
                chk(wgate == r_isw, "R7", wgate, r_isw);
                if (r_isw) begin
                    wr_done = 1'b1;
                    if (r_rec == 2) last_wr_pending = 1;
                end else begin
                    rd_done = 1'b1;
                    rd_err  = (r_rec == err_rec);
                end
            end
        end
    end

    // completion monitor
    initial forever begin
        @(negedge clk);
        if (done) begin
            if (exp_stat.size() == 0) begin
                chk(1'b0, "R11", status, -1);
            end else begin
                d_exp = exp_stat.pop_front();
                chk(status == 2'(d_exp), cur_tag, status, d_exp);
            end
            chk(exp_ops.size() == 0, cur_tag, exp_ops.size(), 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && wgate == 0, "R1", {busy, done, wgate}, 0);
        chk(rd_req == 0 && wr_req == 0, "R1", {rd_req, wr_req}, 0);
        chk(eng_owner == 0 && status == 0, "R1", {eng_owner, status}, 0);

        // R2 cylinder mismatch
        cur_tag = "R2";
        exp_stat.push_back(2);
        n = ops_seen;
        send_cmd(41, 0, 3, 1'b0);
        chk(done == 1'b1, "R2", done, 1);
        chk(eng_owner == 3'b000, "R2", eng_owner, 0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(ops_seen == n, "R2", ops_seen, n);

        // R5 data-only, mid sector
        cur_tag = "R5";
        do_update(0, 5, 1'b0, -1);
        // R6 label plus data, other head
        cur_tag = "R6";
        do_update(1, 11, 1'b1, -1);
        // R5 highest sector, decoy wraps to 0
        cur_tag = "R5";
        do_update(1, 15, 1'b0, -1);
        // R6 sector 0
        cur_tag = "R6";
        do_update(0, 0, 1'b1, -1);

        // R8 read errors
        cur_tag = "R8";
        do_update(0, 7, 1'b0, 1);
        do_update(1, 2, 1'b1, 0);

        // R9 other machine holds the engines
        cur_tag = "R9";
        oth_req = 2'b01;
        @(negedge clk);
        chk(eng_owner == 3'b010, "R9", eng_owner, 3'b010);
        push_plan(0, 1'b1, -1);
        n = ops_seen;
        send_cmd(40, 0, 9, 1'b1);
        repeat (4) @(negedge clk);
        mark(9);
        repeat (3) @(negedge clk);
        chk(eng_owner == 3'b010 && busy, "R9", eng_owner, 3'b010);
        chk(ops_seen == n, "R9", ops_seen, n);
        oth_req = 2'b00;
        repeat (3) @(negedge clk);
        chk(eng_owner == 3'b001, "R9", eng_owner, 3'b001);
        mark(9);
        wait_idle();
        chk(eng_owner == 3'b000, "R10", eng_owner, 0);

        // R9 lowest index wins, then hand over
        oth_req = 2'b11;
        @(negedge clk);
        chk(eng_owner == 3'b010, "R9", eng_owner, 3'b010);
        oth_req = 2'b10;
        repeat (2) @(negedge clk);
        chk(eng_owner == 3'b100, "R9", eng_owner, 3'b100);
        oth_req = 2'b00;
        repeat (2) @(negedge clk);

        // R11 command while busy is ignored
        cur_tag = "R11";
        push_plan(1, 1'b0, -1);
        send_cmd(40, 1, 4, 1'b0);
        repeat (3) @(negedge clk);
        send_cmd(99, 0, 8, 1'b1);
        mark(4);
        wait_idle();
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R11", busy, 0);
        chk(exp_stat.size() == 0, "R11", exp_stat.size(), 0);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule